// File: doc/BRIEF.md
# Store-multiple register sequencer

This block carries out one store-multiple-words instruction. It decodes a 32-bit instruction word into a base register, a first data register, a 9-bit signed displacement and a word count. It reads the base register once and keeps that value. It then walks through consecutive register numbers and issues one 32-bit store for each of them. The stores go to consecutive word-sized slots that begin at the base value plus the displacement. The resulting byte address may have any alignment and is passed to memory as it is.

The instruction arrives on a valid/ready stream. `insn_ready` is high only while the block is idle, and a word is taken on a clock edge where both `insn_valid` and `insn_ready` are high. The store interface also uses valid/ready. Once `mem_req_valid` rises, it stays high with address and data unchanged until `mem_req_ready` is seen high. After that the block waits for exactly one response (`mem_rsp_valid`, with `mem_rsp_fault`) before it reads the next register. Only one store is ever outstanding. The response must arrive no earlier than the cycle after the request is accepted.

If memory reports a fault, the block stops, pulses `fault_o` and returns to idle. Stores already made stay made, and the whole instruction is restarted from its first word by reissuing it. If the feature-disable input is set when an instruction is taken, the block pulses `ri_trap_o` and makes no store.

Top module: `stm_seq`

## Requirements
- R1: The displacement is the sign extension to 32 bits of the 9-bit value {insn_word[15], insn_word[7:0]}. The first data register is insn_word[25:21] and the base register is insn_word[20:16]. The major opcode in bits 31:26 is 101001, bits 11:10 are 1 and bits 9:8 are 01; the bench always supplies these values.
- R2: The word count is insn_word[14:12], except that a value of 0 means 8 words.
- R3: Store i (i from 0 to count-1) goes to address base + displacement + 4*i, modulo 2^32, for any byte alignment. No alignment error exists.
- R4: Store i takes its data from register first+i when first+i < 32, and from register first+i-16 otherwise, so numbering continues at 16 after 31.
- R5: When the first data register is 0, register 0 (value zero) is stored for every step.
- R6: When cfg_feat_off is 1 at the edge where an instruction is taken, ri_trap_o is high for exactly the next cycle and no store is issued.
- R7: A store request holds its address and data until it is accepted. No new request is raised until the response to the previous one has arrived, and each step is stored exactly once.
- R8: A faulting response ends the instruction. fault_o is high for one cycle in the cycle after that response, no later step is issued and done_o does not pulse.
- R9: done_o is high for one cycle in the cycle after the last response arrives without a fault.
- R10: The base register is read once, before the first store. A change to that register while the instruction runs does not move the later addresses.
- R11: insn_ready is high exactly while the block is idle. No store request is raised while it is idle. Coming out of reset, the block is idle with every pulse output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_feat_off | input | 1 | Feature disable; an instruction taken while this is high traps |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Block is idle and takes the word |
| insn_word | input | 32 | Instruction word |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data, valid in the same cycle |
| mem_req_valid | output | 1 | Store request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Store byte address, any alignment |
| mem_req_data | output | 32 | Store data word |
| mem_rsp_valid | input | 1 | Response to the outstanding store |
| mem_rsp_fault | input | 1 | Response reports a fault |
| done_o | output | 1 | One-cycle pulse: all words stored |
| fault_o | output | 1 | One-cycle pulse: instruction aborted, restart it |
| ri_trap_o | output | 1 | One-cycle pulse: reserved-instruction trap |

## Verification
The hardest situation to reach from the ports is a fault in the middle of the instruction that is followed by a clean restart, together with the base register changing after the sequence has started. The bench's memory responder is told which store index should fault. It also overwrites the base register in the bench's register file at the moment the first store is seen, and updates the expected data of any later step that reads that register. Random ready stalls and random response latency let the hold and one-outstanding rules be exercised across many timings.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int INSN_W = 32;
  localparam int OFF_W  = 9;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic [4:0]       first_reg;
    logic [4:0]       base_reg;
    logic [OFF_W-1:0] disp;
    logic [CNT_W-1:0] words;
  } insn_fields_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BASE,
    S_READ,
    S_ISSUE,
    S_WAIT
  } seq_state_t;
endpackage

// File: rtl/stm_decode.sv
module stm_decode
  import stm_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_fields_t      fields
);
  logic [2:0] cnt_field;
  logic       unused_fixed;

  assign cnt_field    = insn[14:12];
  assign unused_fixed = ^{insn[31:26], insn[11:8]};

  always_comb begin
    fields.first_reg = insn[25:21];
    fields.base_reg  = insn[20:16];
    fields.disp      = {insn[15], insn[7:0]};
    fields.words     = (cnt_field == 3'd0) ? CNT_W'(8) : CNT_W'(cnt_field);
  end
endmodule

// File: rtl/stm_regstep.sv
module stm_regstep #(
  parameter int REG_W     = 5,
  parameter int STEP_W    = 4,
  parameter int WRAP_BASE = 16
) (
  input  logic [REG_W-1:0]  first,
  input  logic [STEP_W-1:0] step,
  output logic [REG_W-1:0]  idx
);
  localparam int NREG  = 1 << REG_W;
  localparam int SUM_W = REG_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  assign sum     = {1'b0, first} + SUM_W'(step);
  assign wrapped = sum - SUM_W'(NREG - WRAP_BASE);

  always_comb begin
    if (first == '0)
      idx = '0;
    else if (sum < SUM_W'(NREG))
      idx = sum[REG_W-1:0];
    else
      idx = wrapped[REG_W-1:0];
  end
endmodule

// File: rtl/stm_addrgen.sv
module stm_addrgen #(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 9,
  parameter int STEP_W = 4
) (
  input  logic [XLEN-1:0]   base,
  input  logic [OFF_W-1:0]  disp,
  input  logic [STEP_W-1:0] step,
  output logic [XLEN-1:0]   addr
);
  localparam int SHIFT = $clog2(XLEN / 8);

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] step_bytes;

  assign disp_ext   = {{(XLEN-OFF_W){disp[OFF_W-1]}}, disp};
  assign step_bytes = XLEN'(step) << SHIFT;
  assign addr       = base + disp_ext + step_bytes;
endmodule

// File: rtl/stm_seq.sv
module stm_seq
  import stm_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int WRAP_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_feat_off,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [INSN_W-1:0] insn_word,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [XLEN-1:0]   mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_fault,
  output logic              done_o,
  output logic              fault_o,
  output logic              ri_trap_o
);
  seq_state_t       state_q;
  insn_fields_t     dec_f;
  insn_fields_t     fld_q;
  logic [XLEN-1:0]  base_q;
  logic [CNT_W-1:0] step_q;
  logic [XLEN-1:0]  addr_q;
  logic [XLEN-1:0]  data_q;
  logic             done_q;
  logic             fault_q;
  logic             trap_q;
  logic [REG_W-1:0] step_reg;
  logic [XLEN-1:0]  step_addr;
  logic             last_step;
  logic             take_insn;

  stm_decode u_dec (
    .insn   (insn_word),
    .fields (dec_f)
  );

  stm_regstep #(
    .REG_W     (REG_W),
    .STEP_W    (CNT_W),
    .WRAP_BASE (WRAP_BASE)
  ) u_regstep (
    .first (fld_q.first_reg[REG_W-1:0]),
    .step  (step_q),
    .idx   (step_reg)
  );

  stm_addrgen #(
    .XLEN   (XLEN),
    .OFF_W  (OFF_W),
    .STEP_W (CNT_W)
  ) u_addr (
    .base (base_q),
    .disp (fld_q.disp),
    .step (step_q),
    .addr (step_addr)
  );

  assign insn_ready    = (state_q == S_IDLE);
  assign take_insn     = insn_valid && insn_ready;
  assign last_step     = (step_q == fld_q.words - CNT_W'(1));
  assign rf_raddr      = (state_q == S_BASE) ? fld_q.base_reg[REG_W-1:0] : step_reg;
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = addr_q;
  assign mem_req_data  = data_q;
  assign done_o        = done_q;
  assign fault_o       = fault_q;
  assign ri_trap_o     = trap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fld_q   <= '0;
      base_q  <= '0;
      step_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      trap_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (take_insn) begin
            if (cfg_feat_off) begin
              trap_q <= 1'b1;
            end else begin
              fld_q   <= dec_f;
              state_q <= S_BASE;
            end
          end
        end
        S_BASE: begin
          base_q  <= rf_rdata;
          step_q  <= '0;
          state_q <= S_READ;
        end
        S_READ: begin
          data_q  <= rf_rdata;
          addr_q  <= step_addr;
          state_q <= S_ISSUE;
        end
        S_ISSUE: begin
          if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_fault) begin
              fault_q <= 1'b1;
              state_q <= S_IDLE;
            end else if (last_step) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              step_q  <= step_q + CNT_W'(1);
              state_q <= S_READ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stm_seq_chk.sv
module stm_seq_chk #(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_feat_off,
  input logic             insn_valid,
  input logic             insn_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [XLEN-1:0]  mem_req_addr,
  input logic [XLEN-1:0]  mem_req_data,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_fault,
  input logic             done_o,
  input logic             fault_o,
  input logic             ri_trap_o
);
  logic [XLEN-1:0] prev_addr;
  logic            have_prev;
  logic            outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr   <= '0;
      have_prev   <= 1'b0;
      outstanding <= 1'b0;
    end else begin
      if (insn_valid && insn_ready) have_prev <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        prev_addr   <= mem_req_addr;
        have_prev   <= 1'b1;
        outstanding <= 1'b1;
      end else if (mem_rsp_valid) begin
        outstanding <= 1'b0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid); // R7
  AST_WORD_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && have_prev |-> mem_req_addr == prev_addr + XLEN'(4)); // R3
  AST_TRAP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_ready && cfg_feat_off |=> ri_trap_o && !mem_req_valid); // R6
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(mem_rsp_valid && mem_rsp_fault)); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_rsp_valid && !mem_rsp_fault)); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, ri_trap_o})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    insn_ready |-> !mem_req_valid); // R11
endmodule

bind stm_seq stm_seq_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_feat_off  (cfg_feat_off),
  .insn_valid    (insn_valid),
  .insn_ready    (insn_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_data  (mem_req_data),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_fault (mem_rsp_fault),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .ri_trap_o     (ri_trap_o)
);

// File: tb/stm_seq_tb.sv
module stm_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_feat_off = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_word = '0;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_data;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_fault = 1'b0;
  logic        done_o, fault_o, ri_trap_o;

  logic [31:0] regs [32];
  assign rf_rdata = regs[rf_raddr];

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [31:0] rec_addr [16];
  logic [31:0] rec_data [16];
  int          n_rec = 0;
  int          fault_idx = 99;
  bit          clob_en = 1'b0;
  logic [4:0]  cur_rs = '0;
  int          cur_cnt = 0;
  logic [31:0] exp_addr [8];
  logic [31:0] exp_data [8];
  logic [4:0]  exp_reg  [8];

  stm_seq u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_reg(input logic [4:0] rt, input int i);
    int s;
    s = int'(rt) + i;
    if (rt == 0) return 5'd0;
    if (s < 32) return 5'(s);
    return 5'(s - 16);
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] rs,
                                     input logic [8:0] off, input logic [2:0] c3);
    return {6'b101001, rt, rs, off[8], c3, 1'b1, 1'b1, 2'b01, off[7:0]};
  endfunction

  task automatic fill_regs();
    regs[0] = '0;
    for (int k = 1; k < 32; k++) regs[k] = $urandom;
  endtask

  // memory responder with random stalls and latency
  initial begin
    bit pend = 0;
    bit fthis = 0;
    int lat = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_fault = 1'b0;
      if (pend) begin
        mem_req_ready = 1'b0;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_fault = fthis;
          pend = 0;
        end else lat--;
      end else begin
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
          if (n_rec < 16) begin
            rec_addr[n_rec] = mem_req_addr;
            rec_data[n_rec] = mem_req_data;
          end
          fthis = (n_rec == fault_idx);
          if (n_rec == 0 && clob_en && cur_rs != 0) begin
            regs[cur_rs] = regs[cur_rs] ^ 32'hA5A5_0000;
            for (int k = 1; k < cur_cnt; k++)
              if (exp_reg[k] == cur_rs) exp_data[k] = regs[cur_rs];
          end
          n_rec++;
          pend = 1;
          lat = $urandom % 3;
        end
      end
    end
  end

  // watchdog
  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_insn(input logic [31:0] w, input bit fdis, input int f_at,
                          input bit clob, input string tag);
    logic [4:0]  rt, rs;
    logic [31:0] base, disp;
    int cnt, exp_n, waitc;
    bit got_d, got_f, got_t;
    rt   = w[25:21];
    rs   = w[20:16];
    disp = {{23{w[15]}}, w[15], w[7:0]};
    cnt  = (w[14:12] == 0) ? 8 : int'(w[14:12]);
    base = regs[rs];
    for (int k = 0; k < cnt; k++) begin
      exp_reg[k]  = ref_reg(rt, k);
      exp_data[k] = regs[exp_reg[k]];
      exp_addr[k] = base + disp + 32'(4 * k);
    end
    cur_rs = rs; cur_cnt = cnt; clob_en = clob; fault_idx = f_at; n_rec = 0;
    @(negedge clk);
    chk(insn_ready == 1'b1, "R11", {tag, " ready while idle"}, 32'(insn_ready), 1);
    cfg_feat_off = fdis;
    insn_valid = 1'b1;
    insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0;
    cfg_feat_off = 1'b0;
    waitc = 0;
    while (!(done_o || fault_o || ri_trap_o) && waitc < 400) begin
      @(negedge clk);
      waitc++;
    end
    got_d = done_o; got_f = fault_o; got_t = ri_trap_o;
    @(negedge clk);
    chk(!(done_o || fault_o || ri_trap_o), "R9", {tag, " pulse lasts one cycle"},
        32'({done_o, fault_o, ri_trap_o}), 0);
    repeat (3) @(negedge clk);
    if (fdis) begin
      exp_n = 0;
      chk(got_t && !got_d && !got_f, "R6", {tag, " trap outcome"}, 32'({got_d, got_f, got_t}), 1);
    end else if (f_at < cnt) begin
      exp_n = f_at + 1;
      chk(got_f && !got_d && !got_t, "R8", {tag, " fault outcome"}, 32'({got_d, got_f, got_t}), 2);
    end else begin
      exp_n = cnt;
      chk(got_d && !got_f && !got_t, "R9", {tag, " done outcome"}, 32'({got_d, got_f, got_t}), 4);
    end
    chk(n_rec == exp_n, "R2 R7", {tag, " store count"}, 32'(n_rec), 32'(exp_n));
    for (int k = 0; k < exp_n && k < n_rec; k++) begin
      chk(rec_addr[k] == exp_addr[k], "R1 R3 R10", {tag, " store address"}, rec_addr[k], exp_addr[k]);
      chk(rec_data[k] == exp_data[k], "R4 R5", {tag, " store data"}, rec_data[k], exp_data[k]);
    end
    clob_en = 1'b0;
    fault_idx = 99;
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_1234));
    fill_regs();
    repeat (3) @(negedge clk);
    chk(insn_ready == 1'b1, "R11", "reset ready", 32'(insn_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(insn_ready == 1'b1 && !mem_req_valid, "R11", "idle after reset",
        32'({insn_ready, mem_req_valid}), 2);
    chk(!(done_o || fault_o || ri_trap_o), "R11", "pulses low after reset",
        32'({done_o, fault_o, ri_trap_o}), 0);

    // directed cases
    run_insn(mk(5'd3, 5'd9, 9'h010, 3'd3), 0, 99, 0, "r1_basic");
    run_insn(mk(5'd29, 5'd2, 9'h1F0, 3'd6), 0, 99, 0, "r4_wrap");
    run_insn(mk(5'd31, 5'd1, 9'h003, 3'd0), 0, 99, 0, "r2_eight_wrap");
    run_insn(mk(5'd0, 5'd7, 9'h101, 3'd5), 0, 99, 0, "r5_zero_reg");
    regs[4] = 32'hFFFF_FFFE;
    run_insn(mk(5'd10, 5'd4, 9'h0FF, 3'd4), 0, 99, 0, "r3_addr_wrap");
    run_insn(mk(5'd12, 5'd6, 9'h021, 3'd2), 1, 99, 0, "r6_trap");
    fill_regs();
    run_insn(mk(5'd20, 5'd8, 9'h155, 3'd7), 0, 2, 0, "r8_fault_mid");
    run_insn(mk(5'd20, 5'd8, 9'h155, 3'd7), 0, 99, 0, "r8_restart");
    run_insn(mk(5'd14, 5'd14, 9'h006, 3'd4), 0, 99, 1, "r10_base_self");
    run_insn(mk(5'd11, 5'd15, 9'h1FD, 3'd6), 0, 99, 1, "r10_base_later");
    run_insn(mk(5'd5, 5'd3, 9'h008, 3'd1), 0, 0, 0, "r8_fault_first");
    run_insn(mk(5'd26, 5'd30, 9'h044, 3'd0), 0, 7, 0, "r8_fault_last");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int fa;
      bit fd;
      fill_regs();
      w  = mk(5'($urandom), 5'($urandom), 9'($urandom), 3'($urandom));
      fd = ($urandom % 10) == 0;
      fa = (($urandom % 5) == 0) ? int'($urandom % 8) : 99;
      run_insn(w, fd, fa, ($urandom % 4) == 0, "rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule